// File: doc/BRIEF.md
# Sampling-Phase Tuning Sweep Controller

This block runs the receive-clock phase search for a high-speed memory-card interface. When `start` is pulsed, it first looks at the bus clock frequency and the active timing mode. If tuning is not needed, it reports success at once. Otherwise it resets the external delay line. It then walks the sampling phase from the lowest to the highest value. At each step it programs the phase and asks an external test engine to run a tuning-pattern transfer. Every pass is recorded in a bit mask.

After the last phase, a non-empty mask goes to an external window selector. The phase the selector returns is programmed into the delay line as the final setting. An empty mask makes the controller repeat the whole attempt, starting again from the delay-line reset, up to a fixed limit. After that it reports an I/O-type failure. Any sub-operation error ends the run at once with its own error code.

All external operations use a level request that stays high until a one-cycle done strobe returns, with an error flag that is valid alongside done. Only one request is active at a time.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: If `clk_freq` is at most 100_000_000 (Hz), or `timing_mode` is neither 3'd4 nor 3'd6, then a `start` in idle raises `done` on the next cycle with `err` low, and no external request is made.
- R2: A `start` that needs tuning makes the delay-line reset request (`dl_init_req`) the first request. If init returns an error, `err` pulses with `err_code` 3'd1 and no phase is programmed.
- R3: Each attempt programs phases 0,1,…,15 in ascending order through `dl_phase_val`, with exactly one test request after each. A pass at phase i sets bit i of the mask shown on `sel_mask`.
- R4: A phase-programming error, whether in the sweep or in the final write, ends the run with `err_code` 3'd2, and no further request is made.
- R5: An attempt with no passing phase is repeated from the delay-line reset, for at most 3 attempts in total. After the third, `err` pulses with `err_code` 3'd4.
- R6: If any phase passed, the selector is requested with a non-zero mask. Its `sel_phase` is then programmed through `dl_phase_val`. When that write completes, `done` pulses and `final_phase` equals the selected phase.
- R7: A selector error ends the run with `err_code` 3'd3 and no final phase write.
- R8: `done` and `err` are one-cycle pulses and never high together. `final_phase` changes only when `done` pulses and otherwise holds its value, which is 0 after reset.
- R9: At most one of the four requests is high at any time, and a `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (sampled in idle) |
| clk_freq | input | 32 | Bus clock frequency in Hz |
| timing_mode | input | 3 | Active bus timing mode code |
| dl_init_req | output | 1 | Delay-line reset/init request |
| dl_init_done | input | 1 | Init complete strobe |
| dl_init_err | input | 1 | Init failed (with done) |
| dl_phase_req | output | 1 | Program-phase request |
| dl_phase_val | output | 4 | Phase to program |
| dl_phase_done | input | 1 | Phase programmed strobe |
| dl_phase_err | input | 1 | Phase programming failed (with done) |
| test_req | output | 1 | Tuning-pattern test request |
| test_done | input | 1 | Test complete strobe |
| test_pass | input | 1 | Test passed (with done) |
| sel_req | output | 1 | Window selection request |
| sel_mask | output | 16 | Pass mask, bit i = phase i |
| sel_done | input | 1 | Selection complete strobe |
| sel_err | input | 1 | Selection failed (with done) |
| sel_phase | input | 4 | Selected phase (with done) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Failed completion pulse |
| err_code | output | 3 | Cause of last failure (0 none) |
| final_phase | output | 4 | Last phase set by a successful tune |

## Verification
The hardest case to reach is the retry path. To hit it, the test engine must fail every phase of one or more complete attempts and then pass in a later attempt. The bench responders read their pass patterns from a per-attempt mask table, and the attempt number comes from how many delay-line resets they have seen. This makes it possible to script "fail, fail, pass" and "fail three times". The same responders inject an error at a chosen request number, so an abort can be forced in the middle of the sweep.

// File: rtl/tune_pkg.sv
package tune_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_INIT, S_PROG, S_TEST, S_SEL, S_FINAL
   } tune_state_e;

   localparam logic [2:0] E_NONE   = 3'd0;
   localparam logic [2:0] E_INIT   = 3'd1;
   localparam logic [2:0] E_PROG   = 3'd2;
   localparam logic [2:0] E_SEL    = 3'd3;
   localparam logic [2:0] E_NOPASS = 3'd4;
endpackage

// File: rtl/tune_need_chk.sv
module tune_need_chk #(
   parameter int FREQ_W = 32,
   parameter int unsigned FREQ_LIMIT = 100_000_000,
   parameter int MODE_W = 3,
   parameter logic [MODE_W-1:0] MODE_A = 3'd4,
   parameter logic [MODE_W-1:0] MODE_B = 3'd6
) (
   input  logic [FREQ_W-1:0] freq,
   input  logic [MODE_W-1:0] mode,
   output logic              need
);
   if (FREQ_W < 8) begin : g_bad_fw
      $error("tune_need_chk: FREQ_W too small");
   end
   if (MODE_A == MODE_B) begin : g_bad_mode
      $error("tune_need_chk: tuned modes must differ");
   end

   logic fast, tuned_mode;
   assign fast       = freq > FREQ_W'(FREQ_LIMIT);
   assign tuned_mode = (mode == MODE_A) || (mode == MODE_B);
   assign need       = fast && tuned_mode;
endmodule

// File: rtl/tune_pass_mask.sv
module tune_pass_mask #(
   parameter int N = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set_en,
   input  logic [IW-1:0] idx,
   input  logic          pass,
   output logic [N-1:0]  mask
);
   if (N < 2) begin : g_bad_n
      $error("tune_pass_mask: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 mask[i] <= 1'b0;
         else if (clr)                               mask[i] <= 1'b0;
         else if (set_en && pass && idx == IW'(i))   mask[i] <= 1'b1;
      end
   end

   // R3
   mask_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((mask & $past(mask)) == $past(mask)));

   // R3
   mask_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> $countones(mask ^ $past(mask)) <= 1);
endmodule

// File: rtl/tune_attempt_ctr.sv
module tune_attempt_ctr #(
   parameter int MAX = 3,
   localparam int AW = (MAX > 1) ? $clog2(MAX) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] cnt,
   output logic          last
);
   if (MAX < 1) begin : g_bad_max
      $error("tune_attempt_ctr: MAX must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && !last)      cnt <= cnt + 1'b1;
   end

   assign last = (cnt == AW'(MAX - 1));

   // R5
   attempt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= AW'(MAX - 1));
endmodule

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl
   import tune_pkg::*;
#(
   parameter int NUM_PHASES = 16,
   parameter int MAX_ATTEMPTS = 3,
   parameter int FREQ_W = 32,
   parameter int unsigned FREQ_LIMIT = 100_000_000,
   parameter int MODE_W = 3,
   parameter logic [MODE_W-1:0] TUNED_MODE_A = 3'd4,
   parameter logic [MODE_W-1:0] TUNED_MODE_B = 3'd6,
   localparam int PH_W = $clog2(NUM_PHASES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FREQ_W-1:0]     clk_freq,
   input  logic [MODE_W-1:0]     timing_mode,
   output logic                  dl_init_req,
   input  logic                  dl_init_done,
   input  logic                  dl_init_err,
   output logic                  dl_phase_req,
   output logic [PH_W-1:0]       dl_phase_val,
   input  logic                  dl_phase_done,
   input  logic                  dl_phase_err,
   output logic                  test_req,
   input  logic                  test_done,
   input  logic                  test_pass,
   output logic                  sel_req,
   output logic [NUM_PHASES-1:0] sel_mask,
   input  logic                  sel_done,
   input  logic                  sel_err,
   input  logic [PH_W-1:0]       sel_phase,
   output logic                  busy,
   output logic                  done,
   output logic                  err,
   output logic [2:0]            err_code,
   output logic [PH_W-1:0]       final_phase
);
   if (NUM_PHASES < 2) begin : g_bad_np
      $error("tune_sweep_ctrl: NUM_PHASES must be at least 2");
   end
   if (MAX_ATTEMPTS < 1) begin : g_bad_att
      $error("tune_sweep_ctrl: MAX_ATTEMPTS must be at least 1");
   end

   localparam int AW = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;

   tune_state_e           state;
   logic [PH_W-1:0]       ph_idx, chosen, fin_q;
   logic                  done_q, err_q;
   logic [2:0]            code_q;
   logic                  need, last_phase, any_pass, att_last;
   logic [NUM_PHASES-1:0] mask, pass_vec;
   logic [AW-1:0]         att_cnt;
   logic                  mask_clr, att_clr, att_inc, go;

   tune_need_chk #(
      .FREQ_W(FREQ_W), .FREQ_LIMIT(FREQ_LIMIT), .MODE_W(MODE_W),
      .MODE_A(TUNED_MODE_A), .MODE_B(TUNED_MODE_B)
   ) u_need (
      .freq(clk_freq), .mode(timing_mode), .need(need)
   );

   assign go       = (state == S_IDLE) && start;
   assign mask_clr = (state == S_INIT) && dl_init_done && !dl_init_err;

   tune_pass_mask #(.N(NUM_PHASES)) u_mask (
      .clk(clk), .rst_n(rst_n), .clr(mask_clr),
      .set_en((state == S_TEST) && test_done),
      .idx(ph_idx), .pass(test_pass), .mask(mask)
   );

   assign last_phase = (ph_idx == PH_W'(NUM_PHASES - 1));
   assign pass_vec   = test_pass ? (NUM_PHASES'(1) << ph_idx) : '0;
   assign any_pass   = |(mask | pass_vec);
   assign att_clr    = go && need;
   assign att_inc    = (state == S_TEST) && test_done && last_phase && !any_pass;

   tune_attempt_ctr #(.MAX(MAX_ATTEMPTS)) u_att (
      .clk(clk), .rst_n(rst_n), .clr(att_clr), .inc(att_inc),
      .cnt(att_cnt), .last(att_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         ph_idx <= '0;
         chosen <= '0;
         fin_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         code_q <= E_NONE;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               code_q <= E_NONE;
               if (need) state  <= S_INIT;
               else      done_q <= 1'b1;
            end
            S_INIT: if (dl_init_done) begin
               if (dl_init_err) begin
                  state <= S_IDLE; err_q <= 1'b1; code_q <= E_INIT;
               end else begin
                  ph_idx <= '0;
                  state  <= S_PROG;
               end
            end
            S_PROG: if (dl_phase_done) begin
               if (dl_phase_err) begin
                  state <= S_IDLE; err_q <= 1'b1; code_q <= E_PROG;
               end else begin
                  state <= S_TEST;
               end
            end
            S_TEST: if (test_done) begin
               if (!last_phase) begin
                  ph_idx <= ph_idx + 1'b1;
                  state  <= S_PROG;
               end else if (any_pass) begin
                  state <= S_SEL;
               end else if (att_last) begin
                  state <= S_IDLE; err_q <= 1'b1; code_q <= E_NOPASS;
               end else begin
                  state <= S_INIT;
               end
            end
            S_SEL: if (sel_done) begin
               if (sel_err) begin
                  state <= S_IDLE; err_q <= 1'b1; code_q <= E_SEL;
               end else begin
                  chosen <= sel_phase;
                  state  <= S_FINAL;
               end
            end
            S_FINAL: if (dl_phase_done) begin
               if (dl_phase_err) begin
                  state <= S_IDLE; err_q <= 1'b1; code_q <= E_PROG;
               end else begin
                  fin_q  <= chosen;
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign dl_init_req  = (state == S_INIT);
   assign dl_phase_req = (state == S_PROG) || (state == S_FINAL);
   assign dl_phase_val = (state == S_FINAL) ? chosen : ph_idx;
   assign test_req     = (state == S_TEST);
   assign sel_req      = (state == S_SEL);
   assign sel_mask     = mask;
   assign busy         = (state != S_IDLE);
   assign done         = done_q;
   assign err          = err_q;
   assign err_code     = code_q;
   assign final_phase  = fin_q;

   // R9
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dl_init_req, dl_phase_req, test_req, sel_req}));

   // R8
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R8
   final_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(final_phase));

   // R1
   skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !need) |=> (done && !busy));

   // R2
   first_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && need) |=> dl_init_req);

   // R6
   sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_req |-> (sel_mask != '0));
endmodule

// File: tb/tb_tune_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_tune_sweep_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] clk_freq = 32'd0;
   logic [2:0]  timing_mode = 3'd0;
   logic dl_init_req, dl_phase_req, test_req, sel_req;
   logic [3:0] dl_phase_val;
   logic [15:0] sel_mask;
   logic dl_init_done = 0, dl_init_err = 0;
   logic dl_phase_done = 0, dl_phase_err = 0;
   logic test_done = 0, test_pass = 0;
   logic sel_done = 0, sel_err = 0;
   logic [3:0] sel_phase = 4'd0;
   logic busy, done, err;
   logic [2:0] err_code;
   logic [3:0] final_phase;

   always #10 clk = ~clk;

   tune_sweep_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_freq(clk_freq),
      .timing_mode(timing_mode),
      .dl_init_req(dl_init_req), .dl_init_done(dl_init_done), .dl_init_err(dl_init_err),
      .dl_phase_req(dl_phase_req), .dl_phase_val(dl_phase_val),
      .dl_phase_done(dl_phase_done), .dl_phase_err(dl_phase_err),
      .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
      .sel_req(sel_req), .sel_mask(sel_mask), .sel_done(sel_done),
      .sel_err(sel_err), .sel_phase(sel_phase),
      .busy(busy), .done(done), .err(err), .err_code(err_code),
      .final_phase(final_phase)
   );

   int n_chk = 0, n_fail = 0;
   logic [15:0] att_mask [3];
   int init_n, prog_n, test_n, sel_n;
   logic [3:0] prog_log [64];
   logic [15:0] seen_mask;
   bit init_fail = 0, sel_fail = 0;
   int prog_fail_at = -1;
   logic [3:0] cur_ph = 0;
   int w_init = 0, w_ph = 0, w_tst = 0, w_sel = 0;
   int run_cyc;

   task automatic chk(bit ok, string req, int act, int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic logic [3:0] top_bit(logic [15:0] m);
      logic [3:0] r = 0;
      for (int i = 0; i < 16; i++) if (m[i]) r = 4'(i);
      return r;
   endfunction

   // responders: two-cycle latency, one-cycle done strobe
   always @(negedge clk) begin
      if (dl_init_done) begin dl_init_done = 0; dl_init_err = 0; end
      else if (dl_init_req) begin
         w_init++;
         if (w_init == 2) begin
            w_init = 0; dl_init_done = 1; dl_init_err = init_fail; init_n++;
         end
      end
   end
   always @(negedge clk) begin
      if (dl_phase_done) begin dl_phase_done = 0; dl_phase_err = 0; end
      else if (dl_phase_req) begin
         w_ph++;
         if (w_ph == 2) begin
            w_ph = 0; dl_phase_done = 1;
            dl_phase_err = (prog_n == prog_fail_at);
            if (prog_n < 64) prog_log[prog_n] = dl_phase_val;
            cur_ph = dl_phase_val;
            prog_n++;
         end
      end
   end
   always @(negedge clk) begin
      if (test_done) begin test_done = 0; test_pass = 0; end
      else if (test_req) begin
         w_tst++;
         if (w_tst == 2) begin
            w_tst = 0; test_done = 1;
            test_pass = att_mask[(init_n > 3 ? 3 : init_n) - 1][cur_ph];
            test_n++;
         end
      end
   end
   always @(negedge clk) begin
      if (sel_done) begin sel_done = 0; sel_err = 0; end
      else if (sel_req) begin
         w_sel++;
         if (w_sel == 2) begin
            w_sel = 0; sel_done = 1; sel_err = sel_fail;
            sel_phase = top_bit(sel_mask); seen_mask = sel_mask; sel_n++;
         end
      end
   end

   task automatic run(input logic [31:0] f, input logic [2:0] m, input bit poke);
      init_n = 0; prog_n = 0; test_n = 0; sel_n = 0; seen_mask = 0;
      clk_freq = f; timing_mode = m;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      run_cyc = 1;
      while (!(done || err) && run_cyc < 3000) begin
         @(negedge clk);
         run_cyc++;
         start = (poke && run_cyc == 30);
      end
      start = 0;
      if (run_cyc >= 3000) chk(0, "watchdog", run_cyc, 0);
   endtask

   task automatic pulse_width;
      @(negedge clk);
      chk(!done && !err && !busy, "R8 pulse width", {done, err}, 0);
   endtask

   task automatic tuned_case(logic [15:0] m);
      bit order_ok = 1;
      att_mask[0] = m; att_mask[1] = m; att_mask[2] = m;
      run(32'd100_000_001, 3'd6, 0);
      chk(done && !err, "R6 done", {done, err}, 2);
      chk(final_phase == top_bit(m), "R6 final", final_phase, top_bit(m));
      chk(seen_mask == m, "R3 mask", seen_mask, m);
      for (int i = 0; i < 16; i++) if (prog_log[i] != 4'(i)) order_ok = 0;
      chk(order_ok && prog_n == 17 && test_n == 16 && init_n == 1, "R3 order", prog_n, 17);
      chk(prog_log[16] == top_bit(m), "R6 final write", prog_log[16], top_bit(m));
      pulse_width();
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] held;
      att_mask[0] = 0; att_mask[1] = 0; att_mask[2] = 0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && final_phase == 0 &&
          !dl_init_req && !dl_phase_req && !test_req && !sel_req,
          "R8 reset", final_phase, 0);
      rst_n = 1;
      @(negedge clk);

      // R1 skip cases
      run(32'd100_000_000, 3'd4, 0);
      chk(done && !err && run_cyc == 1 && init_n == 0, "R1 freq limit", run_cyc, 1);
      pulse_width();
      run(32'd200_000_000, 3'd5, 0);
      chk(done && !err && run_cyc == 1 && init_n == 0, "R1 mode", run_cyc, 1);
      pulse_width();

      // R3 R6 single-bit and multi-bit masks
      for (int i = 0; i < 16; i++) tuned_case(16'(1) << i);
      tuned_case(16'hF0F0);
      tuned_case(16'h8001);
      tuned_case(16'hFFFF);

      // R8 hold
      held = final_phase;
      repeat (20) @(negedge clk);
      chk(final_phase == held, "R8 hold", final_phase, held);

      // R5 retry then success
      att_mask[0] = 0; att_mask[1] = 0; att_mask[2] = 16'h0300;
      run(32'd150_000_000, 3'd4, 0);
      chk(done && init_n == 3 && test_n == 48, "R5 retry", init_n, 3);
      chk(final_phase == 4'd9, "R5 retry phase", final_phase, 9);
      pulse_width();

      // R5 exhausted
      att_mask[2] = 0;
      run(32'd150_000_000, 3'd4, 0);
      chk(err && err_code == 3'd4, "R5 nopass code", err_code, 4);
      chk(init_n == 3 && sel_n == 0 && prog_n == 48, "R5 attempts", init_n, 3);
      chk(final_phase == 4'd9, "R8 held on err", final_phase, 9);
      pulse_width();

      // R2 init fail
      init_fail = 1;
      run(32'd150_000_000, 3'd6, 0);
      init_fail = 0;
      chk(err && err_code == 3'd1 && prog_n == 0, "R2 init err", err_code, 1);
      pulse_width();

      // R4 program failure mid-sweep
      att_mask[0] = 16'hFFFF; prog_fail_at = 5;
      run(32'd150_000_000, 3'd6, 0);
      prog_fail_at = -1;
      chk(err && err_code == 3'd2, "R4 code", err_code, 2);
      chk(prog_n == 6 && test_n == 5 && sel_n == 0, "R4 stop", prog_n, 6);
      pulse_width();

      // R4 final write failure
      prog_fail_at = 16;
      run(32'd150_000_000, 3'd6, 0);
      prog_fail_at = -1;
      chk(err && err_code == 3'd2 && final_phase == 4'd9, "R4 final err", err_code, 2);
      pulse_width();

      // R7 selector error
      sel_fail = 1;
      run(32'd150_000_000, 3'd6, 0);
      sel_fail = 0;
      chk(err && err_code == 3'd3 && prog_n == 16, "R7 sel err", err_code, 3);
      pulse_width();

      // R9 start while busy ignored
      att_mask[0] = 16'h0010;
      run(32'd150_000_000, 3'd6, 1);
      chk(done && init_n == 1 && prog_n == 17 && final_phase == 4'd4, "R9 busy start", init_n, 1);
      pulse_width();

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule